// File: doc/BRIEF.md
# Dual-Tag Issue Queue Wakeup

This block is the wakeup part of an out-of-order issue queue in which the destination of an instruction is named by a virtual tag at rename, and a physical register is bound to that tag only when the result is about to be written. Each queued instruction keeps, for every source operand, the virtual tag it waits on, the physical register id it will read, and a ready bit. Two broadcast buses update these fields. A completion broadcast carries a virtual tag together with the physical id just bound to it. A steal broadcast carries only a virtual tag whose physical register was taken back. On a completion, matching operands copy the physical id and become ready. On a steal, matching operands fall back to not ready.

Instructions stay resident from allocation until retirement, so a consumer can be sent again when its producer rebinds. Each entry runs a four-state machine: `ST_FREE`, `ST_WAIT`, `ST_ISSUED` and `ST_DONE`. The transitions are:
- *alloc* (`ST_FREE`→`ST_WAIT`)
- *grant* (`ST_WAIT`→`ST_ISSUED`)
- *finish* (`ST_ISSUED`→`ST_DONE`)
- *rewake* (`ST_ISSUED`→`ST_WAIT`, when a completion hits one of its operands)
- *victim* (`ST_ISSUED` or `ST_DONE`→`ST_WAIT`, when its own register is stolen)
- *release* (any state→`ST_FREE`, on retirement or flush)

Entries form a ring ordered by age from a head pointer. A small oldest-first picker exposes the oldest eligible entry so that the queue can be exercised. `DEPTH` must be a power of two.

Top module: `vp_wakeup_iq`

## Requirements
- R1: An allocation is accepted when fewer than `DEPTH` entries are occupied. It is written at the index shown on `alloc_idx`, which then advances by one modulo `DEPTH`. `alloc_ok` is 0 exactly when all `DEPTH` entries are occupied, and an allocation offered then is dropped. A source whose `alloc_used` bit is 0 counts as ready forever.
- R2: A completion broadcast (`cmp_valid`) makes every used operand of an occupied entry whose virtual tag equals `cmp_vtag` take `cmp_pid` and become ready on the next cycle.
- R3: A steal broadcast (`steal_valid`) makes every used operand of an occupied entry whose virtual tag equals `steal_vtag` not ready on the next cycle. The stored physical id is left unchanged.
- R4: When a completion and a steal name the same tag in one cycle, the steal wins. The operand ends not ready and keeps its old physical id.
- R5: An operand being allocated in the same cycle as a broadcast is updated by that broadcast exactly as a resident operand would be, including the R4 priority.
- R6: `issue_valid`/`issue_idx` point at the oldest entry, counted from the head, that is in `ST_WAIT` with all of its used sources ready. `issue_pid` gives that entry's source physical ids, with source s at bits [s*PID_W +: PID_W]. When `issue_en` is high, that entry moves to `ST_ISSUED` and is not picked again.
- R7: A steal broadcast does not cancel an entry that has already been issued. It stays in `ST_ISSUED`.
- R8: A completion broadcast that hits a used operand of an `ST_ISSUED` entry sends that entry back to `ST_WAIT` with the new id. `done_valid`/`done_idx` moves an entry from `ST_ISSUED` to `ST_DONE`, and an entry in `ST_DONE` is never sent again by a completion.
- R9: `steal_valid` with `steal_idx` naming an occupied entry returns that victim entry to `ST_WAIT`.
- R10: `retire_en` frees the head entry when the queue is not empty, and the head advances by one. Age order then wraps around the ring.
- R11: `flush_valid` frees every occupied entry younger than `flush_idx`, and `alloc_idx` becomes `flush_idx`+1. An allocation offered in the flush cycle is dropped.
- R12: After reset the queue is empty: `alloc_ok`=1, `alloc_idx`=0, `issue_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one instruction |
| alloc_used | input | NSRC | Per-source in-use mask |
| alloc_vtag | input | NSRC*VTAG_W | Per-source virtual tag |
| alloc_pid | input | NSRC*PID_W | Per-source physical id known at rename |
| alloc_rdy | input | NSRC | Per-source ready at rename |
| alloc_ok | output | 1 | Queue has a free slot |
| alloc_idx | output | IDX_W | Slot the next allocation uses |
| cmp_valid | input | 1 | Completion broadcast strobe |
| cmp_vtag | input | VTAG_W | Completing virtual tag |
| cmp_pid | input | PID_W | Physical id bound to that tag |
| steal_valid | input | 1 | Steal broadcast strobe |
| steal_vtag | input | VTAG_W | Virtual tag that lost its register |
| steal_idx | input | IDX_W | Queue slot of the victim instruction |
| done_valid | input | 1 | Mark an issued entry completed |
| done_idx | input | IDX_W | Slot being completed |
| issue_en | input | 1 | Take the picked entry |
| issue_valid | output | 1 | An eligible entry exists |
| issue_idx | output | IDX_W | Oldest eligible slot |
| issue_pid | output | NSRC*PID_W | Source physical ids of that slot |
| retire_en | input | 1 | Free the head entry |
| flush_valid | input | 1 | Flush younger entries |
| flush_idx | input | IDX_W | Youngest slot kept by the flush |

## Verification
The bench sweeps every combination of initial readiness, completion match, steal match and broadcast strobes. It does this both for a resident operand and for one arriving in the same cycle. A design that let the completion win a same-tag collision, or that skipped the allocation-cycle bypass, would show an operand ready, or a wrong id, where it must be waiting. Scripted sequences check three more cases: an already issued consumer must survive a steal, an issued but unfinished consumer must come back with the rebound id, and a finished one must not come back. A queue that cancelled on steal, or that ignored the finished state, would raise a pick the bench does not expect. Ring wrap after retirement, and a flush that coincides with an allocation, catch age and tail pointers that are off by one.

// File: rtl/vpwq_pkg.sv
package vpwq_pkg;
    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_ISSUED = 2'd2,
        ST_DONE   = 2'd3
    } ent_state_e;
endpackage

// File: rtl/vpwq_src_wake.sv
// Next-value logic for one source operand under the two broadcasts.
module vpwq_src_wake #(
    parameter int VTAG_W = 6,
    parameter int PID_W  = 5
) (
    input  logic              used,
    input  logic [VTAG_W-1:0] vtag,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic              cur_rdy,
    input  logic              cmp_valid,
    input  logic [VTAG_W-1:0] cmp_vtag,
    input  logic [PID_W-1:0]  cmp_pid,
    input  logic              steal_valid,
    input  logic [VTAG_W-1:0] steal_vtag,
    output logic [PID_W-1:0]  nxt_pid,
    output logic              nxt_rdy,
    output logic              wake_hit
);
    logic steal_hit;

    assign steal_hit = used && steal_valid && (steal_vtag == vtag);
    // a steal on the same tag suppresses the completion
    assign wake_hit  = used && cmp_valid && (cmp_vtag == vtag) && !steal_hit;

    always_comb begin
        nxt_pid = wake_hit ? cmp_pid : cur_pid;
        if (steal_hit)     nxt_rdy = 1'b0;
        else if (wake_hit) nxt_rdy = 1'b1;
        else               nxt_rdy = cur_rdy;
    end
endmodule

// File: rtl/vpwq_entry.sv
// One queue slot: lifecycle state machine plus operand fields.
module vpwq_entry
    import vpwq_pkg::*;
#(
    parameter int NSRC   = 2,
    parameter int VTAG_W = 6,
    parameter int PID_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         free_req,
    input  logic                         alloc_we,
    input  logic [NSRC-1:0]              in_used,
    input  logic [NSRC-1:0][VTAG_W-1:0]  in_vtag,
    input  logic [NSRC-1:0][PID_W-1:0]   in_pid,
    input  logic [NSRC-1:0]              in_rdy,
    input  logic                         victim_req,
    input  logic                         done_req,
    input  logic                         grant_req,
    input  logic                         cmp_valid,
    input  logic [VTAG_W-1:0]            cmp_vtag,
    input  logic [PID_W-1:0]             cmp_pid,
    input  logic                         steal_valid,
    input  logic [VTAG_W-1:0]            steal_vtag,
    output ent_state_e                   state,
    output logic [NSRC-1:0]              src_used,
    output logic [NSRC-1:0][VTAG_W-1:0]  src_vtag,
    output logic [NSRC-1:0][PID_W-1:0]   src_pid,
    output logic [NSRC-1:0]              src_rdy,
    output logic                         all_rdy
);
    ent_state_e                  st_q, st_d;
    logic [NSRC-1:0]             used_q;
    logic [NSRC-1:0][VTAG_W-1:0] vtag_q;
    logic [NSRC-1:0][PID_W-1:0]  pid_q;
    logic [NSRC-1:0]             rdy_q;
    logic [NSRC-1:0][PID_W-1:0]  pid_nx;
    logic [NSRC-1:0]             rdy_nx;
    logic [NSRC-1:0]             hit;
    logic                        wake_any;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        vpwq_src_wake #(.VTAG_W(VTAG_W), .PID_W(PID_W)) u_wake (
            .used        (used_q[s]),
            .vtag        (vtag_q[s]),
            .cur_pid     (pid_q[s]),
            .cur_rdy     (rdy_q[s]),
            .cmp_valid   (cmp_valid),
            .cmp_vtag    (cmp_vtag),
            .cmp_pid     (cmp_pid),
            .steal_valid (steal_valid),
            .steal_vtag  (steal_vtag),
            .nxt_pid     (pid_nx[s]),
            .nxt_rdy     (rdy_nx[s]),
            .wake_hit    (hit[s])
        );
    end

    assign wake_any = |hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_FREE;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FREE:   if (alloc_we) st_d = ST_WAIT;
            ST_WAIT:   if (grant_req) st_d = ST_ISSUED;
            ST_ISSUED: begin
                if (done_req)      st_d = ST_DONE;
                else if (wake_any) st_d = ST_WAIT;
            end
            ST_DONE:   st_d = ST_DONE;
        endcase
        if (victim_req && st_q != ST_FREE) st_d = ST_WAIT;
        if (free_req) st_d = ST_FREE;
    end

    // operand fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
            vtag_q <= '0;
            pid_q  <= '0;
            rdy_q  <= '0;
        end else if (alloc_we) begin
            used_q <= in_used;
            vtag_q <= in_vtag;
            pid_q  <= in_pid;
            rdy_q  <= in_rdy;
        end else begin
            pid_q  <= pid_nx;
            rdy_q  <= rdy_nx;
        end
    end

    // outputs
    always_comb begin
        state    = st_q;
        src_used = used_q;
        src_vtag = vtag_q;
        src_pid  = pid_q;
        src_rdy  = rdy_q;
        all_rdy  = &(rdy_q | ~used_q);
    end
endmodule

// File: rtl/vpwq_age_pick.sv
// Oldest-first selection over a ring starting at the head slot.
module vpwq_age_pick #(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] elig,
    input  logic [IDX_W-1:0] head,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [IDX_W-1:0] pos;
            pos = head + IDX_W'(k);
            if (!found && elig[pos]) begin
                found = 1'b1;
                idx   = pos;
            end
        end
    end
endmodule

// File: rtl/vp_wakeup_iq.sv
module vp_wakeup_iq
    import vpwq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int NSRC   = 2,
    parameter int VTAG_W = 6,
    parameter int PID_W  = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_valid,
    input  logic [NSRC-1:0]             alloc_used,
    input  logic [NSRC-1:0][VTAG_W-1:0] alloc_vtag,
    input  logic [NSRC-1:0][PID_W-1:0]  alloc_pid,
    input  logic [NSRC-1:0]             alloc_rdy,
    output logic                        alloc_ok,
    output logic [IDX_W-1:0]            alloc_idx,
    input  logic                        cmp_valid,
    input  logic [VTAG_W-1:0]           cmp_vtag,
    input  logic [PID_W-1:0]            cmp_pid,
    input  logic                        steal_valid,
    input  logic [VTAG_W-1:0]           steal_vtag,
    input  logic [IDX_W-1:0]            steal_idx,
    input  logic                        done_valid,
    input  logic [IDX_W-1:0]            done_idx,
    input  logic                        issue_en,
    output logic                        issue_valid,
    output logic [IDX_W-1:0]            issue_idx,
    output logic [NSRC-1:0][PID_W-1:0]  issue_pid,
    input  logic                        retire_en,
    input  logic                        flush_valid,
    input  logic [IDX_W-1:0]            flush_idx
);
    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0] head_q, tail_q, count;
    logic [IDX_W-1:0] head_idx, flush_age;
    logic             full, empty, alloc_fire, retire_fire, flush_ok;

    logic [NSRC-1:0][PID_W-1:0]         in_pid;
    logic [NSRC-1:0]                    in_rdy;
    logic [NSRC-1:0]                    in_hit;

    logic [DEPTH-1:0]                   ent_free, ent_wait, ent_issued, ent_elig;
    logic [DEPTH-1:0][NSRC-1:0]         ent_used, ent_rdy;
    logic [DEPTH-1:0][NSRC-1:0][VTAG_W-1:0] ent_vtag;
    logic [DEPTH-1:0][NSRC-1:0][PID_W-1:0]  ent_pid;

    assign count       = tail_q - head_q;
    assign head_idx    = head_q[IDX_W-1:0];
    assign full        = (count == PTR_W'(DEPTH));
    assign empty       = (count == '0);
    assign flush_age   = flush_idx - head_idx;
    assign flush_ok    = flush_valid && ({1'b0, flush_age} < count);
    assign alloc_fire  = alloc_valid && !full && !flush_valid;
    assign retire_fire = retire_en && !empty;
    assign alloc_ok    = !full;
    assign alloc_idx   = tail_q[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            head_q <= head_q + PTR_W'(retire_fire);
            if (flush_ok) tail_q <= head_q + {1'b0, flush_age} + PTR_W'(1);
            else          tail_q <= tail_q + PTR_W'(alloc_fire);
        end
    end

    // broadcasts seen in the allocation cycle apply to the incoming operands
    for (genvar s = 0; s < NSRC; s++) begin : g_byp
        vpwq_src_wake #(.VTAG_W(VTAG_W), .PID_W(PID_W)) u_byp (
            .used        (alloc_used[s]),
            .vtag        (alloc_vtag[s]),
            .cur_pid     (alloc_pid[s]),
            .cur_rdy     (alloc_rdy[s] | ~alloc_used[s]),
            .cmp_valid   (cmp_valid),
            .cmp_vtag    (cmp_vtag),
            .cmp_pid     (cmp_pid),
            .steal_valid (steal_valid),
            .steal_vtag  (steal_vtag),
            .nxt_pid     (in_pid[s]),
            .nxt_rdy     (in_rdy[s]),
            .wake_hit    (in_hit[s])
        );
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [IDX_W-1:0] age;
        logic             in_use, free_req;
        ent_state_e       st;
        logic             all_rdy;

        assign age      = IDX_W'(i) - head_idx;
        assign in_use   = {1'b0, age} < count;
        assign free_req = (retire_fire && head_idx == IDX_W'(i))
                       || (flush_ok && in_use && age > flush_age);

        vpwq_entry #(.NSRC(NSRC), .VTAG_W(VTAG_W), .PID_W(PID_W)) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .free_req    (free_req),
            .alloc_we    (alloc_fire && alloc_idx == IDX_W'(i)),
            .in_used     (alloc_used),
            .in_vtag     (alloc_vtag),
            .in_pid      (in_pid),
            .in_rdy      (in_rdy),
            .victim_req  (steal_valid && steal_idx == IDX_W'(i)),
            .done_req    (done_valid && done_idx == IDX_W'(i)),
            .grant_req   (issue_en && issue_valid && issue_idx == IDX_W'(i)),
            .cmp_valid   (cmp_valid),
            .cmp_vtag    (cmp_vtag),
            .cmp_pid     (cmp_pid),
            .steal_valid (steal_valid),
            .steal_vtag  (steal_vtag),
            .state       (st),
            .src_used    (ent_used[i]),
            .src_vtag    (ent_vtag[i]),
            .src_pid     (ent_pid[i]),
            .src_rdy     (ent_rdy[i]),
            .all_rdy     (all_rdy)
        );

        assign ent_free[i]   = (st == ST_FREE);
        assign ent_wait[i]   = (st == ST_WAIT);
        assign ent_issued[i] = (st == ST_ISSUED);
        assign ent_elig[i]   = ent_wait[i] && all_rdy;
    end

    vpwq_age_pick #(.DEPTH(DEPTH)) u_pick (
        .elig  (ent_elig),
        .head  (head_idx),
        .found (issue_valid),
        .idx   (issue_idx)
    );

    assign issue_pid = ent_pid[issue_idx];
endmodule

// File: rtl/vpwq_chk.sv
module vpwq_chk #(
    parameter int DEPTH  = 8,
    parameter int NSRC   = 2,
    parameter int VTAG_W = 6,
    parameter int PID_W  = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  alloc_ok,
    input logic                                  cmp_valid,
    input logic [VTAG_W-1:0]                     cmp_vtag,
    input logic [PID_W-1:0]                      cmp_pid,
    input logic                                  steal_valid,
    input logic [VTAG_W-1:0]                     steal_vtag,
    input logic [IDX_W-1:0]                      steal_idx,
    input logic                                  done_valid,
    input logic [IDX_W-1:0]                      done_idx,
    input logic                                  issue_en,
    input logic                                  issue_valid,
    input logic [IDX_W-1:0]                      issue_idx,
    input logic                                  retire_en,
    input logic                                  flush_valid,
    input logic [DEPTH-1:0]                      ent_free,
    input logic [DEPTH-1:0]                      ent_wait,
    input logic [DEPTH-1:0]                      ent_issued,
    input logic [DEPTH-1:0][NSRC-1:0]            ent_used,
    input logic [DEPTH-1:0][NSRC-1:0]            ent_rdy,
    input logic [DEPTH-1:0][NSRC-1:0][VTAG_W-1:0] ent_vtag,
    input logic [DEPTH-1:0][NSRC-1:0][PID_W-1:0]  ent_pid
);
    // R1
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alloc_ok |-> (ent_free == '0));

    // R6
    pick_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> (ent_wait[issue_idx]
                         && ((ent_rdy[issue_idx] | ~ent_used[issue_idx]) == '1)));

    // R6
    grant_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en && issue_valid && !flush_valid && !retire_en
         && !steal_valid && !done_valid)
        |=> ent_issued[$past(issue_idx)]);

    for (genvar i = 0; i < DEPTH; i++) begin : g_e
        // R7
        no_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ent_issued[i] && !cmp_valid && !(steal_valid && steal_idx == IDX_W'(i))
             && !(done_valid && done_idx == IDX_W'(i)) && !flush_valid && !retire_en)
            |=> ent_issued[i]);

        for (genvar s = 0; s < NSRC; s++) begin : g_s
            // R3 R4
            steal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (steal_valid && !ent_free[i] && ent_used[i][s]
                 && ent_vtag[i][s] == steal_vtag)
                |=> (ent_free[i] || !ent_rdy[i][s]));

            // R2
            cmp_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cmp_valid && !(steal_valid && steal_vtag == cmp_vtag)
                 && !ent_free[i] && ent_used[i][s] && ent_vtag[i][s] == cmp_vtag)
                |=> (ent_free[i] || (ent_rdy[i][s] && ent_pid[i][s] == $past(cmp_pid))));
        end
    end
endmodule

bind vp_wakeup_iq vpwq_chk #(
    .DEPTH(DEPTH), .NSRC(NSRC), .VTAG_W(VTAG_W), .PID_W(PID_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_ok    (alloc_ok),
    .cmp_valid   (cmp_valid),
    .cmp_vtag    (cmp_vtag),
    .cmp_pid     (cmp_pid),
    .steal_valid (steal_valid),
    .steal_vtag  (steal_vtag),
    .steal_idx   (steal_idx),
    .done_valid  (done_valid),
    .done_idx    (done_idx),
    .issue_en    (issue_en),
    .issue_valid (issue_valid),
    .issue_idx   (issue_idx),
    .retire_en   (retire_en),
    .flush_valid (flush_valid),
    .ent_free    (ent_free),
    .ent_wait    (ent_wait),
    .ent_issued  (ent_issued),
    .ent_used    (ent_used),
    .ent_rdy     (ent_rdy),
    .ent_vtag    (ent_vtag),
    .ent_pid     (ent_pid)
);

// File: tb/vp_wakeup_iq_tb.sv
module vp_wakeup_iq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int NSRC   = 2;
    localparam int VTAG_W = 6;
    localparam int PID_W  = 5;
    localparam int IDX_W  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic                        alloc_valid;
    logic [NSRC-1:0]             alloc_used;
    logic [NSRC-1:0][VTAG_W-1:0] alloc_vtag;
    logic [NSRC-1:0][PID_W-1:0]  alloc_pid;
    logic [NSRC-1:0]             alloc_rdy;
    logic                        alloc_ok;
    logic [IDX_W-1:0]            alloc_idx;
    logic                        cmp_valid;
    logic [VTAG_W-1:0]           cmp_vtag;
    logic [PID_W-1:0]            cmp_pid;
    logic                        steal_valid;
    logic [VTAG_W-1:0]           steal_vtag;
    logic [IDX_W-1:0]            steal_idx;
    logic                        done_valid;
    logic [IDX_W-1:0]            done_idx;
    logic                        issue_en;
    logic                        issue_valid;
    logic [IDX_W-1:0]            issue_idx;
    logic [NSRC-1:0][PID_W-1:0]  issue_pid;
    logic                        retire_en;
    logic                        flush_valid;
    logic [IDX_W-1:0]            flush_idx;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vp_wakeup_iq #(.DEPTH(DEPTH), .NSRC(NSRC), .VTAG_W(VTAG_W), .PID_W(PID_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_used(alloc_used), .alloc_vtag(alloc_vtag),
        .alloc_pid(alloc_pid), .alloc_rdy(alloc_rdy), .alloc_ok(alloc_ok), .alloc_idx(alloc_idx),
        .cmp_valid(cmp_valid), .cmp_vtag(cmp_vtag), .cmp_pid(cmp_pid),
        .steal_valid(steal_valid), .steal_vtag(steal_vtag), .steal_idx(steal_idx),
        .done_valid(done_valid), .done_idx(done_idx),
        .issue_en(issue_en), .issue_valid(issue_valid), .issue_idx(issue_idx), .issue_pid(issue_pid),
        .retire_en(retire_en), .flush_valid(flush_valid), .flush_idx(flush_idx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        alloc_valid = 0; alloc_used = '0; alloc_vtag = '0; alloc_pid = '0; alloc_rdy = '0;
        cmp_valid = 0; cmp_vtag = '0; cmp_pid = '0;
        steal_valid = 0; steal_vtag = '0; steal_idx = '0;
        done_valid = 0; done_idx = '0; issue_en = 0;
        retire_en = 0; flush_valid = 0; flush_idx = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    // set allocation fields for source 0 only; source 1 unused
    task automatic set_alloc(input logic u0, input int v0, input int p0, input logic r0);
        alloc_valid  = 1;
        alloc_used   = {1'b0, u0};
        alloc_vtag[0] = VTAG_W'(v0);
        alloc_pid[0]  = PID_W'(p0);
        alloc_rdy    = {1'b0, r0};
    endtask

    task automatic alloc_one(input logic u0, input int v0, input int p0, input logic r0);
        set_alloc(u0, v0, p0, r0);
        tick();
        idle();
    endtask

    task automatic take();
        issue_en = 1; tick(); idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog R1..: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R12
        chk("R12 alloc_ok", int'(alloc_ok), 1);
        chk("R12 alloc_idx", int'(alloc_idx), 0);
        chk("R12 issue_valid", int'(issue_valid), 0);

        // resident operand sweep: R2 R3 R4
        for (int m = 0; m < 32; m++) begin
            bit r0, cv, cm, sv, sm, er;
            int ep;
            r0 = m[0]; cv = m[1]; cm = m[2]; sv = m[3]; sm = m[4];
            er = (sv && sm) ? 1'b0 : ((cv && cm) ? 1'b1 : r0);
            ep = (cv && cm && !(sv && sm)) ? 9 : 1;
            do_reset();
            alloc_one(1'b1, 5, 1, r0);
            cmp_valid = cv; cmp_vtag = cm ? 6'd5 : 6'd6; cmp_pid = 5'd9;
            steal_valid = sv; steal_vtag = sm ? 6'd5 : 6'd7; steal_idx = 3'd7;
            tick(); idle();
            chk("R2 R3 R4 sweep ready", int'(issue_valid), int'(er));
            if (er) chk("R2 R4 sweep pid", int'(issue_pid[0]), ep);
        end

        // allocation-cycle bypass sweep: R5
        for (int m = 0; m < 32; m++) begin
            bit r0, cv, cm, sv, sm, er;
            int ep;
            r0 = m[0]; cv = m[1]; cm = m[2]; sv = m[3]; sm = m[4];
            er = (sv && sm) ? 1'b0 : ((cv && cm) ? 1'b1 : r0);
            ep = (cv && cm && !(sv && sm)) ? 9 : 1;
            do_reset();
            set_alloc(1'b1, 5, 1, r0);
            cmp_valid = cv; cmp_vtag = cm ? 6'd5 : 6'd6; cmp_pid = 5'd9;
            steal_valid = sv; steal_vtag = sm ? 6'd5 : 6'd7; steal_idx = 3'd7;
            tick(); idle();
            chk("R5 bypass ready", int'(issue_valid), int'(er));
            if (er) chk("R5 bypass pid", int'(issue_pid[0]), ep);
        end

        // issue, steal, rewake, finish, victim
        do_reset();
        alloc_one(1'b1, 10, 0, 1'b0);   // slot 0 waits on tag 10
        alloc_one(1'b1, 10, 2, 1'b1);   // slot 1 ready on tag 10, pid 2
        alloc_one(1'b0, 0, 0, 1'b0);    // slot 2 no sources
        chk("R1 unused source ready / R6 oldest", int'(issue_idx), 1);
        chk("R6 pid", int'(issue_pid[0]), 2);
        take();
        chk("R6 next oldest", int'(issue_idx), 2);
        take();
        chk("R6 issued not repicked", int'(issue_valid), 0);
        cmp_valid = 1; cmp_vtag = 6'd10; cmp_pid = 5'd3; tick(); idle();
        chk("R2 wake slot0", int'(issue_idx), 0);
        chk("R2 pid slot0", int'(issue_pid[0]), 3);
        take();
        chk("R8 rewake issued slot1", int'(issue_idx), 1);
        chk("R8 new pid slot1", int'(issue_pid[0]), 3);
        take();
        chk("R6 none left", int'(issue_valid), 0);
        done_valid = 1; done_idx = 3'd1; tick(); idle();
        steal_valid = 1; steal_vtag = 6'd10; steal_idx = 3'd7; tick(); idle();
        chk("R7 steal keeps issued", int'(issue_valid), 0);
        cmp_valid = 1; cmp_vtag = 6'd10; cmp_pid = 5'd4; tick(); idle();
        chk("R8 rewake slot0", int'(issue_valid), 1);
        chk("R8 rewake idx", int'(issue_idx), 0);
        chk("R8 rewake pid", int'(issue_pid[0]), 4);
        take();
        chk("R8 done entry stays", int'(issue_valid), 0);
        steal_valid = 1; steal_vtag = 6'd20; steal_idx = 3'd1; tick(); idle();
        chk("R9 victim back", int'(issue_valid), 1);
        chk("R9 victim idx", int'(issue_idx), 1);
        chk("R9 victim pid", int'(issue_pid[0]), 4);

        // fill, full, retire and wrap: R1 R10
        do_reset();
        for (int k = 0; k < DEPTH; k++) begin
            chk("R1 alloc_idx", int'(alloc_idx), k);
            chk("R1 alloc_ok", int'(alloc_ok), 1);
            alloc_one(1'b0, 0, 0, 1'b0);
        end
        chk("R1 full", int'(alloc_ok), 0);
        alloc_one(1'b1, 30, 0, 1'b0);   // dropped
        chk("R1 full still", int'(alloc_ok), 0);
        retire_en = 1; tick(); tick(); idle();
        chk("R10 alloc_ok", int'(alloc_ok), 1);
        chk("R10 alloc_idx", int'(alloc_idx), 0);
        chk("R10 head oldest", int'(issue_idx), 2);
        alloc_one(1'b1, 30, 0, 1'b0);   // slot 0 waiting
        alloc_one(1'b0, 0, 0, 1'b0);    // slot 1 ready
        for (int k = 2; k < DEPTH; k++) begin
            chk("R10 age order", int'(issue_idx), k);
            take();
        end
        chk("R10 wrapped order", int'(issue_idx), 1);
        take();
        chk("R10 waiting slot", int'(issue_valid), 0);

        // flush with a colliding allocation: R11
        do_reset();
        for (int k = 0; k < 6; k++) alloc_one(1'b0, 0, 0, 1'b0);
        flush_valid = 1; flush_idx = 3'd2;
        set_alloc(1'b0, 0, 0, 1'b0);
        tick(); idle();
        chk("R11 tail after flush", int'(alloc_idx), 3);
        chk("R11 alloc_ok", int'(alloc_ok), 1);
        for (int k = 0; k < 3; k++) begin
            chk("R11 kept", int'(issue_idx), k);
            take();
        end
        chk("R11 younger freed", int'(issue_valid), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule